// File: doc/BRIEF.md
# Packet Header ECC Codec

This block protects the 24-bit header of a serial-link packet (an 8-bit data identifier plus a 16-bit word count) with an 8-bit Hamming-style code. The code is the same for short and long packets. It corrects any single flipped bit and detects any pair of flipped bits. The transmit path takes a header and returns the 32-bit header word with the code byte appended. The receive path takes a 32-bit header word, recomputes the code, compares it with the received code byte and classifies the result.

Both paths are valid-qualified and registered, so each has one clock of latency. On a correctable error the receive path returns the repaired word. For a header-bit error that means the flipped bit is restored. For an error confined to the code byte, the code is regenerated. An uncorrectable word is passed through untouched, and its status marks it as unusable.

Top module: `hdr_ecc_codec`

## Requirements
- R1: One clock after `tx_valid_i` is high, `tx_valid_o` is high and `tx_pkt_o` holds the header in bits 23:0 and the code in bits 31:24, with bits 31:30 always 0. Header layout: data identifier in 7:0, word count low byte in 15:8, word count high byte in 23:16.
- R2: Header 24'h000001 (identifier 01h, word count 0000h) yields code byte 8'h07, so the packet word is 32'h07000001.
- R3: A received word whose code matches its header gives status 2'b00 (clean), and the word is returned unchanged.
- R4: A single flipped bit in header bits 23:0 gives status 2'b01 (header corrected), and the output carries the original header and code.
- R5: A single flipped bit in code bits 29:24 gives status 2'b10 (code corrected). The header is unchanged and the code is regenerated.
- R6: A single set bit in code bits 31:30, with the rest consistent, gives status 2'b10, and those bits are cleared in the output.
- R7: Any two flipped bits anywhere in the 32-bit word give status 2'b11 (uncorrectable), and the received word is returned unchanged.
- R8: `rx_valid_o` and `tx_valid_o` are high exactly one clock after their input valid, including on back-to-back words.
- R9: While an input valid is low, the matching output word and status hold their last value.
- R10: While `rst_ni` is low, both output valids, both output words and the status are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_valid_i | input | 1 | Transmit header valid |
| tx_hdr_i | input | 24 | Header to encode |
| tx_valid_o | output | 1 | Encoded word valid |
| tx_pkt_o | output | 32 | Header with appended code |
| rx_valid_i | input | 1 | Received word valid |
| rx_pkt_i | input | 32 | Received header word with code |
| rx_valid_o | output | 1 | Checked word valid |
| rx_pkt_o | output | 32 | Corrected or passed-through word |
| rx_status_o | output | 2 | 00 clean, 01 header fixed, 10 code fixed, 11 uncorrectable |

## Verification
The assertions run on every cycle and check the following:
- valid timing and holding of outputs;
- that clean and uncorrectable words leave the block untouched;
- that a header correction changes exactly one header bit and leaves the code bits alone;
- that a code-only correction leaves the header intact with zero top bits.

Only the bench scenarios can show that the right bit was repaired and that the generated code values are correct. The bench covers the known 01h/07h pair, each error class, the top code bits and double errors that mix header and code bits. These cases are compared against a reference model built from per-parity-bit masks.

// File: rtl/hdr_ecc_pkg.sv
package hdr_ecc_pkg;
  localparam int HDR_W = 24;
  localparam int PAR_W = 6;
  localparam int ECC_W = 8;
  localparam int PKT_W = HDR_W + ECC_W;

  typedef enum logic [1:0] {
    ST_CLEAN   = 2'b00,
    ST_HDR_FIX = 2'b01,
    ST_ECC_FIX = 2'b10,
    ST_UNCORR  = 2'b11
  } ecc_status_e;

  // parity-check column of header bit idx; every column has odd weight >= 3
  function automatic logic [PAR_W-1:0] col_of(int unsigned idx);
    logic [PAR_W-1:0] c;
    case (idx)
      0:  c = 6'h07;  1:  c = 6'h0B;  2:  c = 6'h0D;  3:  c = 6'h0E;
      4:  c = 6'h13;  5:  c = 6'h15;  6:  c = 6'h16;  7:  c = 6'h19;
      8:  c = 6'h1A;  9:  c = 6'h1C;  10: c = 6'h23;  11: c = 6'h25;
      12: c = 6'h26;  13: c = 6'h29;  14: c = 6'h2A;  15: c = 6'h2C;
      16: c = 6'h31;  17: c = 6'h32;  18: c = 6'h34;  19: c = 6'h38;
      20: c = 6'h1F;  21: c = 6'h2F;  22: c = 6'h37;  23: c = 6'h3B;
      default: c = '0;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/hdr_ecc_calc.sv
module hdr_ecc_calc
  import hdr_ecc_pkg::*;
(
  input  logic [HDR_W-1:0] hdr_i,
  output logic [PAR_W-1:0] par_o
);
  always_comb begin
    par_o = '0;
    for (int unsigned i = 0; i < HDR_W; i++) begin
      if (hdr_i[i]) par_o = par_o ^ col_of(i);
    end
  end
endmodule

// File: rtl/hdr_ecc_decode.sv
module hdr_ecc_decode
  import hdr_ecc_pkg::*;
(
  input  logic [ECC_W-1:0] syn_i,
  output logic [HDR_W-1:0] flip_o,
  output ecc_status_e      status_o
);
  localparam int PAD_W = ECC_W - PAR_W;

  for (genvar g = 0; g < HDR_W; g++) begin : g_col
    assign flip_o[g] = (syn_i == {{PAD_W{1'b0}}, col_of(g)});
  end

  logic ecc_hit;
  assign ecc_hit = $onehot(syn_i);

  always_comb begin
    if (syn_i == '0)   status_o = ST_CLEAN;
    else if (|flip_o)  status_o = ST_HDR_FIX;
    else if (ecc_hit)  status_o = ST_ECC_FIX;
    else               status_o = ST_UNCORR;
  end
endmodule

// File: rtl/hdr_ecc_codec.sv
module hdr_ecc_codec
  import hdr_ecc_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        tx_valid_i,
  input  logic [23:0] tx_hdr_i,
  output logic        tx_valid_o,
  output logic [31:0] tx_pkt_o,
  input  logic        rx_valid_i,
  input  logic [31:0] rx_pkt_i,
  output logic        rx_valid_o,
  output logic [31:0] rx_pkt_o,
  output logic [1:0]  rx_status_o
);
  localparam int PAD_W = ECC_W - PAR_W;

  // transmit
  logic [PAR_W-1:0] tx_par;
  hdr_ecc_calc u_tx_calc (.hdr_i(tx_hdr_i), .par_o(tx_par));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_valid_o <= 1'b0;
      tx_pkt_o   <= '0;
    end else begin
      tx_valid_o <= tx_valid_i;
      if (tx_valid_i) tx_pkt_o <= {{PAD_W{1'b0}}, tx_par, tx_hdr_i};
    end
  end

  // receive
  logic [HDR_W-1:0] rx_hdr;
  logic [ECC_W-1:0] rx_ecc;
  logic [PAR_W-1:0] rx_par;
  logic [ECC_W-1:0] rx_syn;
  logic [HDR_W-1:0] rx_flip;
  ecc_status_e      rx_st;
  logic [PKT_W-1:0] rx_fixed;

  assign rx_hdr = rx_pkt_i[HDR_W-1:0];
  assign rx_ecc = rx_pkt_i[PKT_W-1:HDR_W];

  hdr_ecc_calc u_rx_calc (.hdr_i(rx_hdr), .par_o(rx_par));

  // top code bits expected zero, so they enter the syndrome as-is
  assign rx_syn = {rx_ecc[ECC_W-1:PAR_W], rx_par ^ rx_ecc[PAR_W-1:0]};

  hdr_ecc_decode u_dec (.syn_i(rx_syn), .flip_o(rx_flip), .status_o(rx_st));

  always_comb begin
    unique case (rx_st)
      ST_HDR_FIX: rx_fixed = {{PAD_W{1'b0}}, rx_ecc[PAR_W-1:0], rx_hdr ^ rx_flip};
      ST_ECC_FIX: rx_fixed = {{PAD_W{1'b0}}, rx_par, rx_hdr};
      default:    rx_fixed = rx_pkt_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_valid_o  <= 1'b0;
      rx_pkt_o    <= '0;
      rx_status_o <= ST_CLEAN;
    end else begin
      rx_valid_o <= rx_valid_i;
      if (rx_valid_i) begin
        rx_pkt_o    <= rx_fixed;
        rx_status_o <= rx_st;
      end
    end
  end
endmodule

// File: rtl/hdr_ecc_codec_chk.sv
module hdr_ecc_codec_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        tx_valid_i,
  input logic [23:0] tx_hdr_i,
  input logic        tx_valid_o,
  input logic [31:0] tx_pkt_o,
  input logic        rx_valid_i,
  input logic [31:0] rx_pkt_i,
  input logic        rx_valid_o,
  input logic [31:0] rx_pkt_o,
  input logic [1:0]  rx_status_o
);
  // R8
  rx_valid_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_i |=> rx_valid_o);
  // R8
  rx_valid_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_valid_i |=> !rx_valid_o);
  // R8
  tx_valid_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_i |=> tx_valid_o);
  // R1
  tx_pkt_form_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_i |=> (tx_pkt_o[23:0] == $past(tx_hdr_i)) && (tx_pkt_o[31:30] == 2'b00));
  // R9
  rx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_valid_i |=> $stable(rx_pkt_o) && $stable(rx_status_o));
  // R9
  tx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_valid_i |=> $stable(tx_pkt_o));
  // R3
  clean_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_i |=> (rx_status_o == 2'b00) -> (rx_pkt_o == $past(rx_pkt_i)));
  // R7
  uncorr_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_i |=> (rx_status_o == 2'b11) -> (rx_pkt_o == $past(rx_pkt_i)));
  // R4
  hdr_fix_one_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_i |=> (rx_status_o == 2'b01) ->
      (($countones(rx_pkt_o[23:0] ^ $past(rx_pkt_i[23:0])) == 1) &&
       (rx_pkt_o[29:24] == $past(rx_pkt_i[29:24]))));
  // R5 R6
  ecc_fix_hdr_kept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_i |=> (rx_status_o == 2'b10) ->
      ((rx_pkt_o[23:0] == $past(rx_pkt_i[23:0])) && (rx_pkt_o[31:30] == 2'b00)));
endmodule

bind hdr_ecc_codec hdr_ecc_codec_chk u_chk (.*);

// File: tb/tb_hdr_ecc_codec.sv
module tb_hdr_ecc_codec;
  localparam int CLK_PERIOD = 10;
  localparam int N_VEC = 12;
  localparam int WDOG = 5000;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        tx_valid_i;
  logic [23:0] tx_hdr_i;
  logic        tx_valid_o;
  logic [31:0] tx_pkt_o;
  logic        rx_valid_i;
  logic [31:0] rx_pkt_i;
  logic        rx_valid_o;
  logic [31:0] rx_pkt_o;
  logic [1:0]  rx_status_o;

  hdr_ecc_codec dut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // header, injected error mask, expected status (00 clean,01 hdr,10 code,11 uncorr)
  localparam logic [23:0] V_HDR [N_VEC] = '{
    24'h000001, 24'h123456, 24'hFFFFFF, 24'h0A0B29, 24'h00FF39, 24'h123456,
    24'h3E1234, 24'hABCDEF, 24'h555555, 24'h000000, 24'h001019, 24'h000000};
  localparam logic [31:0] V_ERR [N_VEC] = '{
    32'h0000_0000, 32'h0000_0000, 32'h0000_0001, 32'h0080_0000, 32'h0100_0000, 32'h2000_0000,
    32'h8000_0000, 32'h0000_0003, 32'h0100_0001, 32'hC000_0000, 32'h0030_0000, 32'h0000_0100};
  localparam logic [1:0] V_ST [N_VEC] = '{
    2'b00, 2'b00, 2'b01, 2'b01, 2'b10, 2'b10,
    2'b10, 2'b11, 2'b11, 2'b11, 2'b11, 2'b01};

  localparam logic [23:0] PMASK [6] = '{
    24'hF12CB7, 24'hF2555B, 24'h749A6D, 24'hB8E38E, 24'hDF03F0, 24'hEFFC00};

  function automatic logic [31:0] golden(logic [23:0] h);
    logic [7:0] e;
    e = 8'h00;
    for (int k = 0; k < 6; k++) e[k] = ^(h & PMASK[k]);
    return {e, h};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  initial begin
    int cyc;
    for (cyc = 0; cyc < WDOG && !done; cyc++) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] last_exp;
    logic [1:0]  last_st;
    rst_ni = 1'b0;
    tx_valid_i = 1'b0; tx_hdr_i = '0;
    rx_valid_i = 1'b0; rx_pkt_i = '0;
    repeat (3) @(negedge clk_i);
    // R10 reset state
    chk("R10 rx_valid", {31'b0, rx_valid_o}, 32'h0);
    chk("R10 tx_valid", {31'b0, tx_valid_o}, 32'h0);
    chk("R10 rx_pkt", rx_pkt_o, 32'h0);
    chk("R10 tx_pkt", tx_pkt_o, 32'h0);
    chk("R10 status", {30'b0, rx_status_o}, 32'h0);
    rst_ni = 1'b1;

    // R2 known pair through the reference model itself
    chk("R2 reference pair", golden(24'h000001), 32'h07000001);

    last_exp = '0; last_st = '0;
    for (int i = 0; i <= N_VEC; i++) begin
      @(negedge clk_i);
      if (i > 0) begin
        chk("R8 rx_valid", {31'b0, rx_valid_o}, 32'h1);
        chk("R8 tx_valid", {31'b0, tx_valid_o}, 32'h1);
        chk("R1 tx_pkt", tx_pkt_o, golden(V_HDR[i-1]));
        if (V_HDR[i-1] == 24'h000001 && V_ERR[i-1] == 0)
          chk("R2 tx 01h->07h", tx_pkt_o, 32'h07000001);
        case (V_ST[i-1])
          2'b00: chk("R3 status", {30'b0, rx_status_o}, 32'h0);
          2'b01: chk("R4 status", {30'b0, rx_status_o}, 32'h1);
          2'b10: chk(V_ERR[i-1][31:30] != 0 ? "R6 status" : "R5 status",
                     {30'b0, rx_status_o}, 32'h2);
          default: chk("R7 status", {30'b0, rx_status_o}, 32'h3);
        endcase
        if (V_ST[i-1] == 2'b11)
          chk("R7 rx_pkt passthru", rx_pkt_o, golden(V_HDR[i-1]) ^ V_ERR[i-1]);
        else
          chk("R3 R4 R5 R6 rx_pkt", rx_pkt_o, golden(V_HDR[i-1]));
        last_exp = rx_pkt_o;
        last_st  = rx_status_o;
      end
      if (i < N_VEC) begin
        rx_valid_i = 1'b1;
        rx_pkt_i   = golden(V_HDR[i]) ^ V_ERR[i];
        tx_valid_i = 1'b1;
        tx_hdr_i   = V_HDR[i];
      end else begin
        rx_valid_i = 1'b0;
        rx_pkt_i   = 32'hDEAD_BEEF;
        tx_valid_i = 1'b0;
        tx_hdr_i   = 24'h777777;
      end
    end

    // R9 idle inputs with changing data: outputs hold
    @(negedge clk_i);
    chk("R8 rx_valid low", {31'b0, rx_valid_o}, 32'h0);
    chk("R8 tx_valid low", {31'b0, tx_valid_o}, 32'h0);
    chk("R9 rx_pkt hold", rx_pkt_o, last_exp);
    chk("R9 status hold", {30'b0, rx_status_o}, {30'b0, last_st});
    chk("R9 tx_pkt hold", tx_pkt_o, golden(V_HDR[N_VEC-1]));

    // R4 every header bit flipped once on one header
    for (int b = 0; b < 24; b++) begin
      rx_valid_i = 1'b1;
      rx_pkt_i   = golden(24'h5A3C96) ^ (32'h1 << b);
      @(negedge clk_i);
      chk("R4 sweep pkt", rx_pkt_o, golden(24'h5A3C96));
      chk("R4 sweep status", {30'b0, rx_status_o}, 32'h1);
    end
    // R5 every low code bit flipped
    for (int b = 24; b < 30; b++) begin
      rx_pkt_i = golden(24'h5A3C96) ^ (32'h1 << b);
      @(negedge clk_i);
      chk("R5 sweep pkt", rx_pkt_o, golden(24'h5A3C96));
      chk("R5 sweep status", {30'b0, rx_status_o}, 32'h2);
    end
    rx_valid_i = 1'b0;

    // R10 reset mid-stream
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    chk("R10 async rx_pkt", rx_pkt_o, 32'h0);
    chk("R10 async rx_valid", {31'b0, rx_valid_o}, 32'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule